// File: doc/BRIEF.md
# MDIO-Addressed PHY Register Set

This block is the management face of an on-chip serializer/link controller. It presents itself on a Clause 22 MDIO management bus as one more PHY, so software reaches it with the same frames it uses for external PHYs. Its PHY address is not fixed. It comes from a configuration input that is programmed elsewhere and held static while frames are in flight.

The block runs on the chip clock and oversamples MDC and MDIO through a two-flop stage. A frame needs at least 32 preamble ones, then the start pattern `01`, then an opcode (`10` read, `01` write), a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits, MSB first.

On a read that matches, the block releases the line during the first turnaround bit and drives zero in the second. It then drives D15 down to D0, changing the output just after each MDC rising edge, and releases the line after the last bit. A write lands in the register after its 16th data bit. Side ports exchange state with the negotiation logic: the block sends out a one-cycle restart request and takes in AN-done, link state, page-received events and the partner's ability word.

Top module: `mdio_phy_regs`

## Requirements
- R1: After reset `mdio_oe_o` and `an_restart_o` are low, and the read/write registers hold their reset values: control 0x1140, advertisement 0x01A0, next-page 0x2001.
- R2: A frame whose PHY-address field differs from `phy_addr_i` leaves `mdio_oe_o` low for the whole frame, and a write in such a frame changes no register.
- R3: On a matched read, `mdio_oe_o` is low while the first turnaround bit is on the line. The block drives 0 in the second turnaround bit, then the 16 data bits MSB first, and releases the line after the last data bit.
- R4: A frame is decoded only if at least 32 consecutive ones come before the start pattern. A frame sent after only 31 ones is ignored.
- R5: Register 0 (control) is read/write. Bit 9 always reads back as 0. A write with bit 9 set gives exactly one clock cycle of `an_restart_o`, and a write with bit 9 clear gives none.
- R6: Register 1 (status) reads 0x0108 in its constant bits, and bit 5 follows `an_done_i` at the time of the read.
- R7: Status bit 2 is latch-low link status. It clears in any cycle in which `link_ok_i` is low and stays clear until it is read. The read returns 0 and reloads the bit from the current `link_ok_i`.
- R8: Registers 2, 3 and 8 to 31 read as 0x0000 and ignore writes.
- R9: Registers 4 (advertisement) and 7 (next-page transmit) are full 16-bit read/write registers.
- R10: Register 5 returns `lp_ability_i` at the time of the read, and writes to it are ignored.
- R11: Register 6 (expansion) reads 0x0004 in its constant bits. Bit 1 is latch-high: a pulse on `page_rx_i` sets it, and it clears only when register 6 is read, after that read has returned 1.
- R12: Frames with opcode `00` or `11` are ignored: no drive and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock; MDC and MDIO are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| phy_addr_i | input | 5 | Programmed PHY address this block answers to |
| mdc_i | input | 1 | Management clock from the bus master |
| mdio_i | input | 1 | Resolved MDIO line as seen by the block |
| mdio_o | output | 1 | Data driven onto MDIO when enabled |
| mdio_oe_o | output | 1 | MDIO drive enable (1 = block drives the line) |
| an_done_i | input | 1 | Negotiation complete, from the negotiation logic |
| link_ok_i | input | 1 | Current link state, from the negotiation logic |
| page_rx_i | input | 1 | One-cycle pulse: a partner page was received |
| lp_ability_i | input | 16 | Link partner base-page ability word |
| an_restart_o | output | 1 | One-cycle request to restart negotiation |

## Verification
The bench counts preamble ones exactly. A decoder that accepts 31 ones, or that needs more than 32, fails the short-preamble and normal frames. It samples the line during both turnaround bits and all 16 data bits. A design that drives one bit early or late shifts every data bit, and one that drives during the first turnaround contends with the master. The latch-low link and latch-high page bits are checked across event, first read and second read. A design that clears on the wrong read, or returns the reloaded value instead of the latched one, misreads in one of those three steps. Frames for other PHY addresses and frames with illegal opcodes are mixed into a seeded random sequence, so a slave that drives or writes on them is caught.

// File: rtl/mdio_phy_pkg.sv
package mdio_phy_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        FS_PRE,
        FS_START,
        FS_OP,
        FS_PHY,
        FS_REG,
        FS_TA1,
        FS_TA2,
        FS_DATA
    } frame_st_e;

    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] OP_RD = 2'b10;

    localparam logic [ADDR_W-1:0] RA_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] RA_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] RA_ANA  = 5'd4;
    localparam logic [ADDR_W-1:0] RA_LPA  = 5'd5;
    localparam logic [ADDR_W-1:0] RA_EXP  = 5'd6;
    localparam logic [ADDR_W-1:0] RA_NPT  = 5'd7;

    localparam int CTRL_RESTART_BIT = 9;
    localparam int STAT_ANDONE_BIT  = 5;
    localparam int STAT_LINK_BIT    = 2;
    localparam int EXP_PAGE_BIT     = 1;

endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_phy_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] phy_addr_i,
    input  logic              mdc_i,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              rd_stb_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [REG_W-1:0]  rd_data_i,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [REG_W-1:0]  wr_data_o
);

    localparam int PRE_CW = $clog2(PRE_LEN + 1);
    localparam int DAT_CW = $clog2(REG_W);
    localparam int CNT_W  = (PRE_CW > DAT_CW) ? PRE_CW : DAT_CW;

    typedef struct packed {
        logic              mdc_s1;
        logic              mdc_s2;
        logic              dat_s1;
        frame_st_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        op;
        logic [ADDR_W-1:0] pa;
        logic [ADDR_W-1:0] ra;
        logic              hit;
        logic              rd;
        logic [REG_W-1:0]  sh;
        logic              oe;
        logic              mdo;
    } eng_t;

    eng_t q, n;
    logic bit_rise;
    logic bit_val;
    logic hit_now;
    logic last_field;
    logic last_data;

    assign bit_rise   = q.mdc_s1 & ~q.mdc_s2;
    assign bit_val    = q.dat_s1;
    assign last_field = (q.cnt == CNT_W'(ADDR_W - 1));
    assign last_data  = (q.cnt == CNT_W'(REG_W - 1));
    assign hit_now    = (q.pa == phy_addr_i) && ((q.op == OP_RD) || (q.op == OP_WR));

    always_comb begin
        n          = q;
        n.mdc_s1   = mdc_i;
        n.mdc_s2   = q.mdc_s1;
        n.dat_s1   = mdio_i;
        rd_stb_o   = 1'b0;
        wr_stb_o   = 1'b0;
        rd_addr_o  = {q.ra[ADDR_W-2:0], bit_val};
        wr_data_o  = {q.sh[REG_W-2:0], bit_val};
        if (bit_rise) begin
            unique case (q.st)
                FS_PRE: begin
                    if (bit_val) begin
                        if (q.cnt < CNT_W'(PRE_LEN)) begin
                            n.cnt = q.cnt + 1'b1;
                        end
                    end else if (q.cnt >= CNT_W'(PRE_LEN)) begin
                        n.st  = FS_START;
                        n.cnt = '0;
                    end else begin
                        n.cnt = '0;
                    end
                end
                FS_START: begin
                    n.cnt = '0;
                    n.st  = bit_val ? FS_OP : FS_PRE;
                end
                FS_OP: begin
                    n.op  = {q.op[0], bit_val};
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(1)) begin
                        n.cnt = '0;
                        n.st  = FS_PHY;
                    end
                end
                FS_PHY: begin
                    n.pa  = {q.pa[ADDR_W-2:0], bit_val};
                    n.cnt = q.cnt + 1'b1;
                    if (last_field) begin
                        n.cnt = '0;
                        n.st  = FS_REG;
                    end
                end
                FS_REG: begin
                    n.ra  = rd_addr_o;
                    n.cnt = q.cnt + 1'b1;
                    if (last_field) begin
                        n.cnt = '0;
                        n.st  = FS_TA1;
                        n.hit = hit_now;
                        n.rd  = (q.op == OP_RD);
                        if (hit_now && (q.op == OP_RD)) begin
                            rd_stb_o = 1'b1;
                            n.sh     = rd_data_i;
                        end
                    end
                end
                FS_TA1: begin
                    if (q.hit && q.rd) begin
                        n.oe  = 1'b1;
                        n.mdo = 1'b0;
                    end
                    n.st = FS_TA2;
                end
                FS_TA2: begin
                    if (q.hit && q.rd) begin
                        n.mdo = q.sh[REG_W-1];
                        n.sh  = {q.sh[REG_W-2:0], 1'b0};
                    end
                    n.cnt = '0;
                    n.st  = FS_DATA;
                end
                FS_DATA: begin
                    if (q.hit && q.rd) begin
                        if (last_data) begin
                            n.oe  = 1'b0;
                            n.mdo = 1'b0;
                        end else begin
                            n.mdo = q.sh[REG_W-1];
                            n.sh  = {q.sh[REG_W-2:0], 1'b0};
                        end
                    end else begin
                        n.sh = wr_data_o;
                        if (last_data && q.hit) begin
                            wr_stb_o = 1'b1;
                        end
                    end
                    n.cnt = q.cnt + 1'b1;
                    if (last_data) begin
                        n.cnt = '0;
                        n.st  = FS_PRE;
                    end
                end
                default: begin
                    n.st  = FS_PRE;
                    n.cnt = '0;
                    n.oe  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign wr_addr_o = q.ra;
    assign mdio_o    = q.mdo;
    assign mdio_oe_o = q.oe;

    assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == FS_PRE) |-> !mdio_oe_o)
        else $error("drive enabled while waiting for preamble");

    assert_ta_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe_o) |-> !mdio_o)
        else $error("second turnaround bit not driven low");

    assert_write_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (q.pa == phy_addr_i))
        else $error("write strobe for a foreign PHY address");

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
    import mdio_phy_pkg::*;
#(
    parameter logic [REG_W-1:0] CTRL_RST   = 16'h1140,
    parameter logic [REG_W-1:0] STAT_CONST = 16'h0108,
    parameter logic [REG_W-1:0] ANA_RST    = 16'h01A0,
    parameter logic [REG_W-1:0] NPT_RST    = 16'h2001,
    parameter logic [REG_W-1:0] EXP_CONST  = 16'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o,
    input  logic              wr_stb_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              an_done_i,
    input  logic              link_ok_i,
    input  logic              page_rx_i,
    input  logic [REG_W-1:0]  lp_ability_i,
    output logic              an_restart_o
);

    localparam logic [REG_W-1:0] RESTART_MASK = REG_W'(1) << CTRL_RESTART_BIT;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] ana;
        logic [REG_W-1:0] npt;
        logic             link_ll;
        logic             page_lh;
        logic             restart;
    } bank_t;

    bank_t q, n;
    logic  rd_stat;
    logic  rd_exp;

    assign rd_stat = rd_stb_i && (rd_addr_i == RA_STAT);
    assign rd_exp  = rd_stb_i && (rd_addr_i == RA_EXP);

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            RA_CTRL: rd_data_o = q.ctrl;
            RA_STAT: begin
                rd_data_o                  = STAT_CONST;
                rd_data_o[STAT_ANDONE_BIT] = an_done_i;
                rd_data_o[STAT_LINK_BIT]   = q.link_ll;
            end
            RA_ANA:  rd_data_o = q.ana;
            RA_LPA:  rd_data_o = lp_ability_i;
            RA_EXP: begin
                rd_data_o               = EXP_CONST;
                rd_data_o[EXP_PAGE_BIT] = q.page_lh;
            end
            RA_NPT:  rd_data_o = q.npt;
            default: rd_data_o = '0;
        endcase
    end

    always_comb begin
        n         = q;
        n.restart = 1'b0;
        if (wr_stb_i) begin
            unique case (wr_addr_i)
                RA_CTRL: begin
                    n.ctrl    = wr_data_i & ~RESTART_MASK;
                    n.restart = wr_data_i[CTRL_RESTART_BIT];
                end
                RA_ANA:  n.ana = wr_data_i;
                RA_NPT:  n.npt = wr_data_i;
                default: ;
            endcase
        end
        n.link_ll = rd_stat ? link_ok_i : (q.link_ll & link_ok_i);
        n.page_lh = page_rx_i | (q.page_lh & ~rd_exp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctrl    <= CTRL_RST & ~RESTART_MASK;
            q.ana     <= ANA_RST;
            q.npt     <= NPT_RST;
            q.link_ll <= 1'b0;
            q.page_lh <= 1'b0;
            q.restart <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign an_restart_o = q.restart;

    assert_restart_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_o |=> !an_restart_o)
        else $error("restart request longer than one cycle");

    assert_link_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !link_ok_i |=> !q.link_ll)
        else $error("latched link not cleared by link loss");

    assert_page_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        page_rx_i |=> q.page_lh)
        else $error("page event not latched");

endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
    import mdio_phy_pkg::*;
#(
    parameter int               PRE_LEN    = 32,
    parameter logic [REG_W-1:0] CTRL_RST   = 16'h1140,
    parameter logic [REG_W-1:0] STAT_CONST = 16'h0108,
    parameter logic [REG_W-1:0] ANA_RST    = 16'h01A0,
    parameter logic [REG_W-1:0] NPT_RST    = 16'h2001,
    parameter logic [REG_W-1:0] EXP_CONST  = 16'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] phy_addr_i,
    input  logic              mdc_i,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              an_done_i,
    input  logic              link_ok_i,
    input  logic              page_rx_i,
    input  logic [REG_W-1:0]  lp_ability_i,
    output logic              an_restart_o
);

    logic              rd_stb;
    logic [ADDR_W-1:0] rd_addr;
    logic [REG_W-1:0]  rd_data;
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [REG_W-1:0]  wr_data;

    mdio_frame_engine #(
        .PRE_LEN (PRE_LEN)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .phy_addr_i (phy_addr_i),
        .mdc_i      (mdc_i),
        .mdio_i     (mdio_i),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe_o),
        .rd_stb_o   (rd_stb),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_data),
        .wr_stb_o   (wr_stb),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    mdio_reg_bank #(
        .CTRL_RST   (CTRL_RST),
        .STAT_CONST (STAT_CONST),
        .ANA_RST    (ANA_RST),
        .NPT_RST    (NPT_RST),
        .EXP_CONST  (EXP_CONST)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_stb_i     (rd_stb),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .wr_stb_i     (wr_stb),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .an_done_i    (an_done_i),
        .link_ok_i    (link_ok_i),
        .page_rx_i    (page_rx_i),
        .lp_ability_i (lp_ability_i),
        .an_restart_o (an_restart_o)
    );

endmodule

// File: tb/mdio_phy_regs_bench.sv
module mdio_phy_regs_bench;

    localparam logic [4:0] MY_ADDR = 5'h13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic        m_en = 1'b0;
    logic        m_bit = 1'b1;
    logic        an_done = 1'b0;
    logic        link_ok = 1'b0;
    logic        page_rx = 1'b0;
    logic [15:0] lp_ab = 16'h41E0;
    logic        mdio_o, mdio_oe, an_restart;
    logic        line;

    int checks = 0;
    int errors = 0;
    int oe_cycles = 0;
    int restart_cycles = 0;
    bit done = 1'b0;

    logic [15:0] m_ctrl = 16'h1140;
    logic [15:0] m_ana  = 16'h01A0;
    logic [15:0] m_npt  = 16'h2001;
    logic        m_ll   = 1'b0;
    logic        m_lh   = 1'b0;

    always #2.5 clk = ~clk;

    assign line = mdio_oe ? mdio_o : (m_en ? m_bit : 1'b1);

    mdio_phy_regs u_mdio_phy_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .phy_addr_i   (MY_ADDR),
        .mdc_i        (mdc),
        .mdio_i       (line),
        .mdio_o       (mdio_o),
        .mdio_oe_o    (mdio_oe),
        .an_done_i    (an_done),
        .link_ok_i    (link_ok),
        .page_rx_i    (page_rx),
        .lp_ability_i (lp_ab),
        .an_restart_o (an_restart)
    );

    always @(posedge clk) begin
        if (mdio_oe) oe_cycles <= oe_cycles + 1;
        if (an_restart) restart_cycles <= restart_cycles + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [4:0] ra);
        logic [15:0] v;
        case (ra)
            5'd0: v = m_ctrl;
            5'd1: begin v = 16'h0108; v[5] = an_done; v[2] = m_ll; end
            5'd4: v = m_ana;
            5'd5: v = lp_ab;
            5'd6: begin v = 16'h0004; v[1] = m_lh; end
            5'd7: v = m_npt;
            default: v = 16'h0000;
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic [4:0] ra);
        case (ra)
            5'd0: return "R5";
            5'd1: return "R6";
            5'd4, 5'd7: return "R9";
            5'd5: return "R10";
            5'd6: return "R11";
            default: return "R8";
        endcase
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        m_en = 1'b1;
        m_bit = b;
        repeat (4) @(negedge clk);
        mdc = 1'b1;
        repeat (4) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic recv_bit(output logic b, output logic oe);
        @(negedge clk);
        m_en = 1'b0;
        repeat (4) @(negedge clk);
        b  = line;
        oe = mdio_oe;
        mdc = 1'b1;
        repeat (4) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic header(input int pre, input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
        for (int i = 0; i < pre; i++) send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 4; i >= 0; i--) send_bit(pa[i]);
        for (int i = 4; i >= 0; i--) send_bit(ra[i]);
    endtask

    task automatic idle_gap();
        @(negedge clk);
        m_en = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic model_write(input logic [4:0] ra, input logic [15:0] d);
        case (ra)
            5'd0: m_ctrl = d & 16'hFDFF;
            5'd4: m_ana = d;
            5'd7: m_npt = d;
            default: ;
        endcase
    endtask

    // Write-type frame (op may be illegal); also checks the restart pulse count.
    task automatic wr_frame(input int pre, input logic [1:0] op, input logic [4:0] pa,
                            input logic [4:0] ra, input logic [15:0] d);
        bit hit;
        int exp_pulse;
        hit = (pre >= 32) && (pa == MY_ADDR) && (op == 2'b01);
        restart_cycles = 0;
        oe_cycles = 0;
        header(pre, op, pa, ra);
        send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 15; i >= 0; i--) send_bit(d[i]);
        idle_gap();
        exp_pulse = (hit && ra == 5'd0 && d[9]) ? 1 : 0;
        chk(restart_cycles == exp_pulse, "R5 restart pulse cycles", restart_cycles, exp_pulse);
        chk(oe_cycles == 0, "R2 no drive during write-type frame", oe_cycles, 0);
        if (hit) model_write(ra, d);
    endtask

    task automatic rd_frame(input int pre, input logic [4:0] pa, input logic [4:0] ra, input string tag);
        logic        b, oe, ta1_oe, ta2_oe, ta2_b;
        logic [15:0] got, exp;
        bit          hit;
        hit = (pre >= 32) && (pa == MY_ADDR);
        exp = exp_read(ra);
        oe_cycles = 0;
        header(pre, 2'b10, pa, ra);
        recv_bit(b, ta1_oe);
        recv_bit(ta2_b, ta2_oe);
        got = '0;
        for (int i = 15; i >= 0; i--) begin
            recv_bit(b, oe);
            got[i] = b;
        end
        idle_gap();
        if (hit) begin
            chk(!ta1_oe && ta2_oe && !ta2_b, "R3 turnaround", {ta1_oe, ta2_oe, ta2_b}, 3'b010);
            chk(!mdio_oe, "R3 released after data", mdio_oe, 0);
            chk(got == exp, tag, got, exp);
            if (ra == 5'd1) m_ll = link_ok;
            if (ra == 5'd6) m_lh = 1'b0;
        end else begin
            chk(oe_cycles == 0, tag, oe_cycles, 0);
        end
    endtask

    task automatic link_drop();
        @(negedge clk) link_ok = 1'b0;
        repeat (3) @(negedge clk);
        link_ok = 1'b1;
        m_ll = 1'b0;
    endtask

    task automatic page_pulse();
        @(negedge clk) page_rx = 1'b1;
        @(negedge clk) page_rx = 1'b0;
        m_lh = 1'b1;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(!mdio_oe && !an_restart, "R1 outputs idle", {mdio_oe, an_restart}, 0);
        rd_frame(32, MY_ADDR, 5'd0, "R1 control reset");
        rd_frame(32, MY_ADDR, 5'd4, "R1 adv reset");
        rd_frame(32, MY_ADDR, 5'd7, "R1 next-page reset");

        // R5 control with restart
        wr_frame(32, 2'b01, MY_ADDR, 5'd0, 16'h1340);
        rd_frame(32, MY_ADDR, 5'd0, "R5 bit9 reads zero");
        wr_frame(32, 2'b01, MY_ADDR, 5'd0, 16'h0140);
        rd_frame(32, MY_ADDR, 5'd0, "R5 control rw");

        // R9 read/write registers
        wr_frame(32, 2'b01, MY_ADDR, 5'd4, 16'hA5C3);
        wr_frame(32, 2'b01, MY_ADDR, 5'd7, 16'h5A3C);
        rd_frame(32, MY_ADDR, 5'd4, "R9 adv rw");
        rd_frame(32, MY_ADDR, 5'd7, "R9 next-page rw");

        // R2 foreign address
        wr_frame(32, 2'b01, 5'h12, 5'd4, 16'h0F0F);
        rd_frame(32, 5'h12, 5'd4, "R2 foreign read not driven");
        rd_frame(32, MY_ADDR, 5'd4, "R2 foreign write ignored");

        // R4 short preamble
        wr_frame(31, 2'b01, MY_ADDR, 5'd4, 16'h1234);
        rd_frame(32, MY_ADDR, 5'd4, "R4 short preamble ignored");

        // R12 illegal opcodes
        wr_frame(32, 2'b11, MY_ADDR, 5'd7, 16'hFFFF);
        wr_frame(32, 2'b00, MY_ADDR, 5'd7, 16'h0000);
        rd_frame(32, MY_ADDR, 5'd7, "R12 illegal opcode ignored");

        // R8 reserved and unimplemented
        wr_frame(32, 2'b01, MY_ADDR, 5'd2, 16'hFFFF);
        rd_frame(32, MY_ADDR, 5'd2, "R8 reserved 2");
        rd_frame(32, MY_ADDR, 5'd3, "R8 reserved 3");
        rd_frame(32, MY_ADDR, 5'd31, "R8 unimplemented 31");

        // R10 partner ability
        lp_ab = 16'hC1A1;
        wr_frame(32, 2'b01, MY_ADDR, 5'd5, 16'h0000);
        rd_frame(32, MY_ADDR, 5'd5, "R10 partner ability");

        // R6 AN done live
        an_done = 1'b1;
        rd_frame(32, MY_ADDR, 5'd1, "R6 an done set");
        an_done = 1'b0;
        rd_frame(32, MY_ADDR, 5'd1, "R6 an done clear");

        // R7 latch-low link
        @(negedge clk) link_ok = 1'b1;
        rd_frame(32, MY_ADDR, 5'd1, "R7 first read latched low");
        rd_frame(32, MY_ADDR, 5'd1, "R7 reloaded high");
        link_drop();
        rd_frame(32, MY_ADDR, 5'd1, "R7 drop held");
        rd_frame(32, MY_ADDR, 5'd1, "R7 recovered");

        // R11 latch-high page
        page_pulse();
        rd_frame(32, MY_ADDR, 5'd6, "R11 page latched");
        rd_frame(32, MY_ADDR, 5'd6, "R11 cleared by read");

        // seeded random mix
        for (int k = 0; k < 60; k++) begin
            logic [4:0]  pa, ra;
            logic [15:0] d;
            int          sel;
            pa  = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : MY_ADDR;
            ra  = ($urandom_range(0, 1) == 0) ? 5'($urandom_range(0, 7)) : 5'($urandom_range(0, 31));
            d   = 16'($urandom);
            sel = $urandom_range(0, 9);
            if (sel == 0) link_drop();
            if (sel == 1) page_pulse();
            if (sel == 2) begin @(negedge clk) an_done = ~an_done; end
            if (sel == 3) begin @(negedge clk) lp_ab = 16'($urandom); end
            if ($urandom_range(0, 1) == 0)
                wr_frame(32, ($urandom_range(0, 7) == 0) ? 2'b11 : 2'b01, pa, ra, d);
            else
                rd_frame(32, pa, ra, tag_of(ra));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule